// File: doc/BRIEF.md
# Lane Condition Mask Collector

This block assembles a wave-wide bit mask from the one-bit results that a vector compare or carry-out operation produces one lane at a time. Each accepted lane result lands in a pending mask that belongs to the scalar register the result is aimed at. Examples of such a register are the condition register, the execution mask, or an explicit scalar destination. Nothing is written to the register file while the operation is in progress. Lanes processed later in the same operation therefore still read the old register contents.

When the operation signals its end, every pending mask is handed out together on the commit outputs one cycle later, along with a single-cycle done pulse. The pending state is then wiped for the next operation. Up to `SLOTS` distinct target registers can be tracked per operation. A typical case is a destination mask together with the execution mask. The block does not compute the compare results.

Top module: `lane_mask_collector`

## Requirements
- R1: After reset, `done` is 0, `commit_vld` is all zero and `commit_mask` is all zero.
- R2: A lane strobe whose lane has its `exec_mask` bit clear is ignored: it claims no slot and sets no bit.
- R3: The first accepted strobe for a target register that holds no slot claims the lowest-numbered free slot. That slot's mask starts at zero, and the lane's bit is set only when `lane_bit` is 1.
- R4: Further accepted strobes for a target that already holds a slot set that lane's bit when `lane_bit` is 1. A 0 result leaves the mask unchanged.
- R5: While an operation is in progress (before `instr_end`), `done` stays 0 and `commit_vld` stays all zero.
- R6: The cycle after `instr_end` is sampled, `done` is 1 for exactly one cycle. In that cycle `commit_vld[k]` marks every claimed slot k, with its register index at `commit_idx[k*IW +: IW]` and its mask at `commit_mask[k*LANES +: LANES]`, where bit n is lane n.
- R7: A lane strobe presented in the same cycle as `instr_end` is included in that commit.
- R8: After a commit, all pending slots are empty, so the next operation starts from zero masks.
- R9: At most `SLOTS` distinct targets are kept per operation. Strobes aimed at any further target are dropped, and a register that no kept strobe targeted gets no commit (its `commit_vld` bit is 0).
- R10: An operation with no accepted strobes still yields the `done` pulse, with `commit_vld` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_mask | input | LANES | Active-lane mask for the current operation |
| lane_vld | input | 1 | Lane result strobe |
| lane_idx | input | $clog2(LANES) | Lane number of the strobe |
| lane_bit | input | 1 | One-bit lane result |
| lane_tgt | input | IW | Scalar register index the result is aimed at |
| instr_end | input | 1 | Last cycle of the operation |
| commit_vld | output | SLOTS | Per-slot write enable of the commit |
| commit_idx | output | SLOTS*IW | Per-slot target register index |
| commit_mask | output | SLOTS*LANES | Per-slot collected mask |
| done | output | 1 | One-cycle commit pulse |

## Verification
The hardest condition to reach is the one where slots run out. A third distinct target has to appear after two others have claimed both slots, and it must be mixed with inactive-lane strobes that must not claim a slot. The random stimulus draws one to three targets per operation from a wide index range and strobes lanes whether or not they are active. A directed case adds a zero execution mask, an empty operation, and a final strobe that coincides with the end pulse.

// File: rtl/lmc_pkg.sv
package lmc_pkg;

    // What a single accepted strobe does to the slot bank
    typedef enum logic [1:0] {
        LMC_IDLE  = 2'd0,
        LMC_HIT   = 2'd1,
        LMC_ALLOC = 2'd2,
        LMC_DROP  = 2'd3
    } lmc_act_e;

    function automatic lmc_act_e lmc_decide(input logic accept,
                                            input logic any_hit,
                                            input logic any_free);
        if (!accept)        return LMC_IDLE;
        else if (any_hit)   return LMC_HIT;
        else if (any_free)  return LMC_ALLOC;
        else                return LMC_DROP;
    endfunction

endpackage

// File: rtl/lmc_match.sv
module lmc_match #(
    parameter int SLOTS = 2,
    parameter int IW    = 7
) (
    input  logic [SLOTS-1:0]    slot_vld,
    input  logic [SLOTS*IW-1:0] slot_idx,
    input  logic [IW-1:0]       tgt,
    output logic [SLOTS-1:0]    hit
);
    for (genvar k = 0; k < SLOTS; k++) begin : g_cmp
        assign hit[k] = slot_vld[k] && (slot_idx[k*IW +: IW] == tgt);
    end
endmodule

// File: rtl/lmc_pick.sv
module lmc_pick #(
    parameter int N = 2
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int k = 0; k < N; k++) begin
            if (req[k] && !found) begin
                grant[k] = 1'b1;
                found    = 1'b1;
            end
        end
        any = found;
    end
endmodule

// File: rtl/lmc_slot.sv
module lmc_slot #(
    parameter int LANES = 32,
    parameter int IW    = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             alloc_en,
    input  logic             hit_en,
    input  logic [LANES-1:0] lane_oh,
    input  logic             lane_bit,
    input  logic [IW-1:0]    tgt,
    output logic             vld,
    output logic [IW-1:0]    idx,
    output logic [LANES-1:0] mask,
    output logic             nxt_vld,
    output logic [IW-1:0]    nxt_idx,
    output logic [LANES-1:0] nxt_mask
);
    always_comb begin
        nxt_vld  = vld;
        nxt_idx  = idx;
        nxt_mask = mask;
        if (alloc_en) begin
            nxt_vld  = 1'b1;
            nxt_idx  = tgt;
            nxt_mask = lane_bit ? lane_oh : '0;
        end else if (hit_en && lane_bit) begin
            nxt_mask = mask | lane_oh;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            vld  <= 1'b0;
            idx  <= '0;
            mask <= '0;
        end else begin
            vld  <= nxt_vld;
            idx  <= nxt_idx;
            mask <= nxt_mask;
        end
    end
endmodule

// File: rtl/lane_mask_collector.sv
module lane_mask_collector
    import lmc_pkg::*;
#(
    parameter int LANES = 32,
    parameter int IW    = 7,
    parameter int SLOTS = 2,
    localparam int LW   = $clog2(LANES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES-1:0]       exec_mask,
    input  logic                   lane_vld,
    input  logic [LW-1:0]          lane_idx,
    input  logic                   lane_bit,
    input  logic [IW-1:0]          lane_tgt,
    input  logic                   instr_end,
    output logic [SLOTS-1:0]       commit_vld,
    output logic [SLOTS*IW-1:0]    commit_idx,
    output logic [SLOTS*LANES-1:0] commit_mask,
    output logic                   done
);
    logic [SLOTS-1:0]       slot_vld;
    logic [SLOTS*IW-1:0]    slot_idx;
    logic [SLOTS*LANES-1:0] slot_mask;
    logic [SLOTS-1:0]       nxt_vld;
    logic [SLOTS*IW-1:0]    nxt_idx;
    logic [SLOTS*LANES-1:0] nxt_mask;
    logic [SLOTS-1:0]       hit, grant, alloc_en, hit_en;
    logic                   any_free, accept;
    logic [LANES-1:0]       lane_oh;
    lmc_act_e               act;

    assign accept  = lane_vld && exec_mask[lane_idx];
    assign lane_oh = LANES'(1) << lane_idx;

    lmc_match #(.SLOTS(SLOTS), .IW(IW)) u_match (
        .slot_vld (slot_vld),
        .slot_idx (slot_idx),
        .tgt      (lane_tgt),
        .hit      (hit)
    );

    lmc_pick #(.N(SLOTS)) u_pick (
        .req   (~slot_vld),
        .grant (grant),
        .any   (any_free)
    );

    assign act      = lmc_decide(accept, |hit, any_free);
    assign alloc_en = (act == LMC_ALLOC) ? grant : '0;
    assign hit_en   = (act == LMC_HIT)   ? hit   : '0;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        lmc_slot #(.LANES(LANES), .IW(IW)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .clear    (instr_end),
            .alloc_en (alloc_en[k]),
            .hit_en   (hit_en[k]),
            .lane_oh  (lane_oh),
            .lane_bit (lane_bit),
            .tgt      (lane_tgt),
            .vld      (slot_vld[k]),
            .idx      (slot_idx[k*IW +: IW]),
            .mask     (slot_mask[k*LANES +: LANES]),
            .nxt_vld  (nxt_vld[k]),
            .nxt_idx  (nxt_idx[k*IW +: IW]),
            .nxt_mask (nxt_mask[k*LANES +: LANES])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            commit_vld  <= '0;
            commit_idx  <= '0;
            commit_mask <= '0;
            done        <= 1'b0;
        end else begin
            done <= instr_end;
            if (instr_end) begin
                commit_vld  <= nxt_vld;
                commit_idx  <= nxt_idx;
                commit_mask <= nxt_mask;
            end else begin
                commit_vld  <= '0;
                commit_idx  <= '0;
                commit_mask <= '0;
            end
        end
    end
endmodule

// File: rtl/lmc_chk.sv
module lmc_chk #(
    parameter int SLOTS = 2,
    parameter int IW    = 7
) (
    input logic                clk,
    input logic                rst,
    input logic                instr_end,
    input logic                done,
    input logic [SLOTS-1:0]    commit_vld,
    input logic [SLOTS*IW-1:0] commit_idx,
    input logic [SLOTS-1:0]    slot_vld
);
    // R5
    commit_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        (|commit_vld) |-> done);

    // R6
    done_follows_end_chk: assert property (@(posedge clk) disable iff (rst)
        instr_end |=> done);

    // R6
    done_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (!instr_end) |=> !done);

    // R8
    pending_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        instr_end |=> (slot_vld == '0) || $past(rst));

    for (genvar i = 0; i < SLOTS; i++) begin : g_a
        for (genvar j = i + 1; j < SLOTS; j++) begin : g_b
            // R9
            distinct_target_chk: assert property (@(posedge clk) disable iff (rst)
                (commit_vld[i] && commit_vld[j]) |->
                (commit_idx[i*IW +: IW] != commit_idx[j*IW +: IW]));
        end
    end
endmodule

bind lane_mask_collector lmc_chk #(.SLOTS(SLOTS), .IW(IW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .instr_end  (instr_end),
    .done       (done),
    .commit_vld (commit_vld),
    .commit_idx (commit_idx),
    .slot_vld   (slot_vld)
);

// File: tb/lane_mask_collector_tb.sv
module lane_mask_collector_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 32;
    localparam int IW    = 7;
    localparam int SLOTS = 2;
    localparam int LW    = $clog2(LANES);

    logic                   clk = 1'b0;
    logic                   rst;
    logic [LANES-1:0]       exec_mask;
    logic                   lane_vld;
    logic [LW-1:0]          lane_idx;
    logic                   lane_bit;
    logic [IW-1:0]          lane_tgt;
    logic                   instr_end;
    logic [SLOTS-1:0]       commit_vld;
    logic [SLOTS*IW-1:0]    commit_idx;
    logic [SLOTS*LANES-1:0] commit_mask;
    logic                   done;

    int n_checks = 0;
    int n_errors = 0;

    // bench model of pending state
    int               m_n;
    logic [IW-1:0]    m_idx  [SLOTS];
    logic [LANES-1:0] m_mask [SLOTS];

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_mask_collector #(.LANES(LANES), .IW(IW), .SLOTS(SLOTS)) u_dut (
        .clk (clk), .rst (rst), .exec_mask (exec_mask), .lane_vld (lane_vld),
        .lane_idx (lane_idx), .lane_bit (lane_bit), .lane_tgt (lane_tgt),
        .instr_end (instr_end), .commit_vld (commit_vld), .commit_idx (commit_idx),
        .commit_mask (commit_mask), .done (done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        m_n = 0;
        for (int k = 0; k < SLOTS; k++) begin
            m_idx[k] = '0;
            m_mask[k] = '0;
        end
    endtask

    // R2 R3 R4 R9 model
    task automatic model_strobe(input int lane, input bit b, input logic [IW-1:0] t);
        int f;
        if (!exec_mask[lane]) return;
        f = -1;
        for (int k = 0; k < m_n; k++) if (m_idx[k] == t) f = k;
        if (f < 0 && m_n < SLOTS) begin
            f = m_n;
            m_idx[f] = t;
            m_mask[f] = '0;
            m_n++;
        end
        if (f >= 0 && b) m_mask[f][lane] = 1'b1;
    endtask

    // drive one strobe at negedge; held through next posedge; optional end in same cycle (R7)
    task automatic strobe(input int lane, input bit b, input logic [IW-1:0] t, input bit with_end);
        @(negedge clk);
        lane_vld  = 1'b1;
        lane_idx  = LW'(lane);
        lane_bit  = b;
        lane_tgt  = t;
        instr_end = with_end;
        model_strobe(lane, b, t);
        if (!with_end) begin
            // R5: nothing committed mid-operation
            check(!done && commit_vld == '0, "R5", {31'd0, done, 30'd0, commit_vld}, 64'd0);
        end
    endtask

    task automatic finish_instr(input bit end_already);
        if (!end_already) begin
            @(negedge clk);
            lane_vld  = 1'b0;
            instr_end = 1'b1;
        end
        @(negedge clk);
        lane_vld  = 1'b0;
        instr_end = 1'b0;
        // R6 commit cycle
        check(done == 1'b1, "R6 done", {63'd0, done}, 64'd1);
        for (int k = 0; k < SLOTS; k++) begin
            bit ev;
            ev = (k < m_n);
            check(commit_vld[k] == ev, (m_n == 0) ? "R10 vld" : "R9 vld",
                  {63'd0, commit_vld[k]}, {63'd0, ev});
            if (ev) begin
                check(commit_idx[k*IW +: IW] == m_idx[k], "R3 idx",
                      64'(commit_idx[k*IW +: IW]), 64'(m_idx[k]));
                check(commit_mask[k*LANES +: LANES] == m_mask[k], "R4 mask",
                      64'(commit_mask[k*LANES +: LANES]), 64'(m_mask[k]));
            end
        end
        @(negedge clk);
        // R6 single-cycle pulse
        check(!done && commit_vld == '0, "R6 pulse", {31'd0, done, 30'd0, commit_vld}, 64'd0);
        model_clear();
    endtask

    initial begin
        int watchdog_hit;
        watchdog_hit = 0;
        fork
            begin
                #(CLK_PERIOD * 150000);
                watchdog_hit = 1;
            end
            begin
                int seed;
                seed = 32'h1b7;
                void'($urandom(seed));
                rst = 1'b1; exec_mask = '0; lane_vld = 1'b0; lane_idx = '0;
                lane_bit = 1'b0; lane_tgt = '0; instr_end = 1'b0;
                model_clear();
                repeat (3) @(negedge clk);
                rst = 1'b0;
                // R1
                check(!done && commit_vld == '0 && commit_mask == '0, "R1",
                      {31'd0, done, 30'd0, commit_vld}, 64'd0);

                // R10 empty operation
                exec_mask = '1;
                finish_instr(1'b0);

                // R2 zero exec: all strobes ignored
                exec_mask = '0;
                for (int l = 0; l < LANES; l += 3) strobe(l, 1'b1, 7'd106, 1'b0);
                finish_instr(1'b0);

                // R9 three targets, third dropped; R7 last strobe with end
                exec_mask = 32'hffff_0f0f;
                strobe(0, 1'b0, 7'd106, 1'b0);
                strobe(1, 1'b1, 7'd126, 1'b0);
                strobe(2, 1'b1, 7'd20,  1'b0);
                strobe(8, 1'b1, 7'd106, 1'b0);
                strobe(4, 1'b1, 7'd106, 1'b0);
                strobe(31, 1'b1, 7'd126, 1'b1);
                finish_instr(1'b1);

                // R8 back-to-back: new operation must not inherit masks
                exec_mask = '1;
                strobe(5, 1'b1, 7'd126, 1'b0);
                finish_instr(1'b0);

                // R3 inactive lane first, then active lane on same target
                exec_mask = 32'h0000_0002;
                strobe(0, 1'b1, 7'd40, 1'b0);
                strobe(1, 1'b0, 7'd41, 1'b0);
                strobe(1, 1'b1, 7'd40, 1'b1);
                finish_instr(1'b1);

                // random operations
                for (int it = 0; it < 60; it++) begin
                    int ntg, sel;
                    logic [IW-1:0] tg [3];
                    bit rev, merge;
                    ntg = 1 + int'($urandom % 3);
                    tg[0] = IW'($urandom);
                    tg[1] = tg[0] + 7'd1 + IW'($urandom % 50);
                    tg[2] = tg[1] + 7'd1 + IW'($urandom % 50);
                    sel = int'($urandom % 4);
                    exec_mask = (sel == 0) ? '1 : (sel == 1) ? '0 : LANES'($urandom);
                    rev   = ($urandom % 2) == 1;
                    merge = ($urandom % 2) == 1;
                    for (int s = 0; s < LANES; s++) begin
                        int l;
                        bit last;
                        l = rev ? (LANES - 1 - s) : s;
                        last = (s == LANES - 1) && merge;
                        if (($urandom % 4) != 0 || last)
                            strobe(l, ($urandom % 2) == 1, tg[$urandom % ntg], last);
                    end
                    finish_instr(merge);
                end
            end
        join_any
        disable fork;
        if (watchdog_hit) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule